// File: doc/BRIEF.md
# Registered ALU with Condition Flags

This block is the arithmetic and logic stage of a small RISC core. On each cycle in which the valid strobe is high, it takes a four-bit operation code and two data operands, A and B. One clock edge later it presents a result, a register write-enable and a four-bit condition-flag nibble. Operand forwarding, decode and the register file sit outside the block.

The operations cover several groups. Two's-complement add and subtract come with carry and signed-overflow reporting. Compare and test update only the flags. The bitwise group has AND, OR and XOR. The shift group has logical left, logical right, arithmetic right and rotate left, and any shift amount is accepted, including amounts at or above the data width. A load-immediate passes B through. Unsigned and signed multiplies take the low half of each operand. The data width and the multiplier half-width are parameters, and both are checked when the design is elaborated.

Top module: `risc_alu`

## Requirements
- R1: Reset clears every output. Each output is registered. In the cycle after `in_valid` is high, `out_valid` is 1 and the result, flags and write-enable reflect that request. In the cycle after `in_valid` is low, `out_valid` and `out_wr` are 0 and `out_result` and `out_flags` hold their previous values.
- R2: The operation codes are ADD=0, SUB=1, CMP=2, TST=3, AND=4, OR=5, XOR=6, LSL=7, LSR=8, ASR=9, ROL=10, LDI=11, MPYU=12 and MPYS=13. `out_wr` is 1 for every defined code except CMP and TST.
- R3: In the flag nibble, zero is bit 0, carry is bit 1, negative is bit 2 and overflow is bit 3. For every defined code, zero means the result is all zeros and negative copies the result's top bit. For CMP and TST, "the result" is the value computed but not written.
- R4: ADD gives A+B modulo 2^W. Carry is the carry out of the top bit. Overflow is set when both operands have the same sign and the sum's sign differs from it. For example, 0x7FFFFFFF+1 sets overflow and 0xFFFFFFFF+1 sets carry.
- R5: SUB and CMP compute A-B. Carry is set when a borrow occurs, that is when A < B unsigned. Overflow is set when the operands' signs differ and the difference's sign differs from A's. For example, 0-1 sets carry and 0x80000000-1 sets overflow.
- R6: TST and AND give A&B, OR gives A|B, XOR gives A^B, and LDI gives B. All of these clear carry and overflow.
- R7: LSL shifts A left by the full unsigned value of B. Carry is the last bit shifted out. An amount above W gives zero with carry clear.
- R8: LSR shifts A right with zero fill by the full unsigned value of B. Carry is the last bit shifted out, and an amount above W gives zero with carry clear. For example, all-ones shifted by 32 gives 0.
- R9: ASR shifts A right with sign fill. At an amount of W or more, the result is W copies of A's sign and carry equals that sign. For example, all-ones shifted by 32 stays all-ones.
- R10: For LSL, LSR and ASR, a zero amount returns A with carry clear. For all four shifts, overflow is set exactly when the result's top bit differs from A's top bit.
- R11: ROL rotates A left by B modulo W and clears carry. For example, rotating 1 by 31 gives 0x80000000.
- R12: MPYU multiplies the low W/2 bits of A and B as unsigned numbers, and MPYS treats those bits as two's complement. The upper operand bits are ignored, and the product is truncated to W bits (sign-extended when W is wider). Both multiplies clear carry and overflow.
- R13: Codes 14 and 15 give a zero result, a clear flag nibble and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_a | input | DATA_W | Operand A (shifted or first source) |
| in_b | input | DATA_W | Operand B (second source, shift amount, immediate) |
| out_valid | output | 1 | Registered request-present flag |
| out_wr | output | 1 | Register write-enable for the result |
| out_result | output | DATA_W | Registered result |
| out_flags | output | 4 | Registered flags {V,N,C,Z} |

## Verification
The bench builds two copies of the block. The first is a 32-bit, 16-bit-multiplier instance, which reaches the exact boundary values and shift sequences listed above, including amounts of 31, 32 and 33 and the multiplier corner products. The second is an 8-bit instance with a 4-bit multiplier half, which makes the sweep affordable: every operand A against sixteen B patterns for all sixteen codes. Those sixteen patterns include shift amounts 0 to 15, so amounts below, at and well above the width are all covered, and operands with dirty upper halves reach the multipliers.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_CMP  = 4'd2,
      OP_TST  = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_LSL  = 4'd7,
      OP_LSR  = 4'd8,
      OP_ASR  = 4'd9,
      OP_ROL  = 4'd10,
      OP_LDI  = 4'd11,
      OP_MPYU = 4'd12,
      OP_MPYS = 4'd13
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_RIGHT = 2'd1,
      SH_ARITH = 2'd2,
      SH_ROT   = 2'd3
   } shift_kind_e;

   // packed MSB first: v=bit3, n=bit2, c=bit1, z=bit0
   typedef struct packed {
      logic v;
      logic n;
      logic c;
      logic z;
   } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         carry,
   output logic         ovf
);
   logic [W-1:0] b_eff;
   logic [W:0]   wide;

   assign b_eff = sub ? ~b : b;
   assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
   assign sum   = wide[W-1:0];
   // on subtraction, a missing carry out means a borrow
   assign carry = sub ? ~wide[W] : wide[W];
   assign ovf   = (a[W-1] == b_eff[W-1]) && (wide[W-1] != a[W-1]);
endmodule

// File: rtl/alu_shift.sv
module alu_shift
   import alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] amt,
   input  shift_kind_e  kind,
   output logic [W-1:0] res,
   output logic         carry,
   output logic         ovf
);
   localparam int SW = $clog2(W);

   logic [W:0]          l_ext;
   logic [W:0]          r_ext;
   logic signed [W:0]   a_ext;
   logic [2*W-1:0]      dbl;
   logic [SW-1:0]       rot_k;

   // one guard bit on the exit side captures the last bit shifted out
   assign l_ext = {1'b0, a} << amt;
   assign r_ext = {a, 1'b0} >> amt;
   assign a_ext = $signed({a, 1'b0}) >>> amt;
   assign rot_k = amt[SW-1:0];
   assign dbl   = {a, a} << rot_k;

   always_comb begin
      case (kind)
         SH_LEFT:  begin res = l_ext[W-1:0]; carry = l_ext[W]; end
         SH_RIGHT: begin res = r_ext[W:1];   carry = r_ext[0]; end
         SH_ARITH: begin res = a_ext[W:1];   carry = a_ext[0]; end
         default:  begin res = dbl[2*W-1:W]; carry = 1'b0;     end
      endcase
   end

   assign ovf = res[W-1] ^ a[W-1];
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
   parameter int W  = 32,
   parameter int MW = 16
) (
   input  logic [MW-1:0] a_lo,
   input  logic [MW-1:0] b_lo,
   input  logic          sgn,
   output logic [W-1:0]  prod
);
   localparam int PW = 2 * MW + 2;

   logic signed [MW:0]   xa;
   logic signed [MW:0]   xb;
   logic signed [PW-1:0] p;

   // one extra bit per operand lets a single signed multiplier serve both modes
   assign xa = {sgn & a_lo[MW-1], a_lo};
   assign xb = {sgn & b_lo[MW-1], b_lo};
   assign p  = PW'(xa) * PW'(xb);

   generate
      if (W <= PW) begin : g_trunc
         assign prod = p[W-1:0];
      end else begin : g_extend
         assign prod = {{(W - PW){p[PW-1]}}, p};
      end
   endgenerate
endmodule

// File: rtl/risc_alu.sv
module risc_alu
   import alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int MUL_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        in_op,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              out_valid,
   output logic              out_wr,
   output logic [DATA_W-1:0] out_result,
   output logic [3:0]        out_flags
);
   localparam logic [DATA_W-1:0] ZERO_W = '0;

   generate
      if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("risc_alu: DATA_W must be a power of two of at least 4");
      end
      if (MUL_W < 1 || 2 * MUL_W > DATA_W) begin : g_bad_mul
         $error("risc_alu: MUL_W must lie in 1..DATA_W/2");
      end
   endgenerate

   logic [DATA_W-1:0] as_sum, sh_res, mul_res;
   logic              as_c, as_v, sh_c, sh_v;
   logic              is_sub;
   shift_kind_e       sh_kind;

   assign is_sub = (in_op != OP_ADD);

   always_comb begin
      case (in_op)
         OP_LSR:  sh_kind = SH_RIGHT;
         OP_ASR:  sh_kind = SH_ARITH;
         OP_ROL:  sh_kind = SH_ROT;
         default: sh_kind = SH_LEFT;
      endcase
   end

   alu_addsub #(.W(DATA_W)) u_addsub (
      .a(in_a), .b(in_b), .sub(is_sub),
      .sum(as_sum), .carry(as_c), .ovf(as_v)
   );

   alu_shift #(.W(DATA_W)) u_shift (
      .a(in_a), .amt(in_b), .kind(sh_kind),
      .res(sh_res), .carry(sh_c), .ovf(sh_v)
   );

   alu_mul #(.W(DATA_W), .MW(MUL_W)) u_mul (
      .a_lo(in_a[MUL_W-1:0]), .b_lo(in_b[MUL_W-1:0]),
      .sgn(in_op == OP_MPYS), .prod(mul_res)
   );

   logic [DATA_W-1:0] nx_res;
   logic              nx_c, nx_v, nx_wr, nx_def;
   alu_flags_t        nx_flags;

   always_comb begin
      nx_res = ZERO_W;
      nx_c   = 1'b0;
      nx_v   = 1'b0;
      nx_wr  = 1'b1;
      nx_def = 1'b1;
      case (in_op)
         OP_ADD, OP_SUB: begin nx_res = as_sum; nx_c = as_c; nx_v = as_v; end
         OP_CMP: begin nx_res = as_sum; nx_c = as_c; nx_v = as_v; nx_wr = 1'b0; end
         OP_TST: begin nx_res = in_a & in_b; nx_wr = 1'b0; end
         OP_AND: nx_res = in_a & in_b;
         OP_OR:  nx_res = in_a | in_b;
         OP_XOR: nx_res = in_a ^ in_b;
         OP_LSL, OP_LSR, OP_ASR: begin nx_res = sh_res; nx_c = sh_c; nx_v = sh_v; end
         OP_ROL: begin nx_res = sh_res; nx_v = sh_v; end
         OP_LDI: nx_res = in_b;
         OP_MPYU, OP_MPYS: nx_res = mul_res;
         default: begin nx_wr = 1'b0; nx_def = 1'b0; end
      endcase
      nx_flags.z = nx_def & (nx_res == ZERO_W);
      nx_flags.n = nx_res[DATA_W-1];
      nx_flags.c = nx_c;
      nx_flags.v = nx_v;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_wr     <= 1'b0;
         out_result <= ZERO_W;
         out_flags  <= 4'h0;
      end else begin
         out_valid <= in_valid;
         out_wr    <= in_valid & nx_wr;
         if (in_valid) begin
            out_result <= nx_res;
            out_flags  <= nx_flags;
         end
      end
   end
endmodule

// File: rtl/risc_alu_chk.sv
module risc_alu_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        in_op,
   input logic [DATA_W-1:0] in_a,
   input logic [DATA_W-1:0] in_b,
   input logic              out_valid,
   input logic              out_wr,
   input logic [DATA_W-1:0] out_result,
   input logic [3:0]        out_flags
);
   // R1
   valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_wr && $stable(out_result) && $stable(out_flags)));
   // R2
   no_write_cmp_tst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_op == 4'd2 || in_op == 4'd3)) |=> !out_wr);
   // R2
   wr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |-> out_valid);
   // R3
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op <= 4'd13) |=> (out_flags[0] == (out_result == '0)));
   // R3
   neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op <= 4'd13) |=> (out_flags[2] == out_result[DATA_W-1]));
   // R6
   logic_clears_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op >= 4'd3 && in_op <= 4'd6) |=> (!out_flags[1] && !out_flags[3]));
   // R6
   ldi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 4'd11) |=> (out_result == $past(in_b)));
   // R12
   mul_clears_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_op == 4'd12 || in_op == 4'd13)) |=> (!out_flags[1] && !out_flags[3]));
   // R13
   unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op >= 4'd14) |=> (!out_wr && out_flags == 4'h0 && out_result == '0));
endmodule

bind risc_alu risc_alu_chk #(.DATA_W(DATA_W)) u_risc_alu_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
   .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_wr(out_wr),
   .out_result(out_result), .out_flags(out_flags)
);

// File: tb/risc_alu_bench.sv
module risc_alu_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic        v32 = 0, v8 = 0;
   logic [3:0]  op32 = 0, op8 = 0;
   logic [31:0] a32 = 0, b32 = 0;
   logic [7:0]  a8 = 0, b8 = 0;
   logic        ov32, wr32, ov8, wr8;
   logic [31:0] r32;
   logic [7:0]  r8;
   logic [3:0]  f32, f8;

   risc_alu u_risc_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(v32), .in_op(op32), .in_a(a32), .in_b(b32),
      .out_valid(ov32), .out_wr(wr32), .out_result(r32), .out_flags(f32));

   risc_alu #(.DATA_W(8), .MUL_W(4)) u_risc_alu_small (
      .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_op(op8), .in_a(a8), .in_b(b8),
      .out_valid(ov8), .out_wr(wr8), .out_result(r8), .out_flags(f8));

   function automatic string tag_of(input int op);
      case (op)
         0: return "R4";
         1, 2: return "R5";
         3, 4, 5, 6, 11: return "R6";
         7: return "R7";
         8: return "R8";
         9: return "R9";
         10: return "R11";
         12, 13: return "R12";
         default: return "R13";
      endcase
   endfunction

   function automatic logic bit_at(input longint unsigned x, input int i);
      return logic'((x >> i) & 1);
   endfunction

   function automatic void model(input int op, input longint unsigned a, input longint unsigned b,
                                 input int w, input int mw, output longint unsigned r,
                                 output logic [3:0] f, output logic we);
      longint unsigned m  = (64'd1 << w) - 1;
      longint unsigned mm = (64'd1 << mw) - 1;
      longint unsigned s;
      longint signed   sx, sy;
      logic c = 0, v = 0, sg;
      we = 1; r = 0;
      case (op)
         0: begin s = a + b; r = s & m; c = bit_at(s, w);
                  v = (bit_at(a, w-1) == bit_at(b, w-1)) && (bit_at(r, w-1) != bit_at(a, w-1)); end
         1, 2: begin r = (a - b) & m; c = (a < b);
                  v = (bit_at(a, w-1) != bit_at(b, w-1)) && (bit_at(r, w-1) != bit_at(a, w-1));
                  we = (op == 1); end
         3: begin r = a & b; we = 0; end
         4: r = a & b;
         5: r = a | b;
         6: r = a ^ b;
         7: begin
               if (b == 0) r = a;
               else if (b <= longint'(w)) begin r = (a << b) & m; c = bit_at(a, w - int'(b)); end
               v = bit_at(r, w-1) != bit_at(a, w-1);
            end
         8: begin
               if (b == 0) r = a;
               else if (b <= longint'(w)) begin r = a >> b; c = bit_at(a, int'(b) - 1); end
               v = bit_at(r, w-1) != bit_at(a, w-1);
            end
         9: begin
               sg = bit_at(a, w-1);
               if (b == 0) r = a;
               else if (b < longint'(w)) begin
                  r = (a >> b) | (sg ? (m & ~(m >> b)) : 64'd0); c = bit_at(a, int'(b) - 1);
               end else begin r = sg ? m : 64'd0; c = sg; end
               v = bit_at(r, w-1) != bit_at(a, w-1);
            end
         10: begin
               s = b % longint'(w);
               r = ((a << s) | (a >> (longint'(w) - s))) & m;
               v = bit_at(r, w-1) != bit_at(a, w-1);
            end
         11: r = b & m;
         12: r = ((a & mm) * (b & mm)) & m;
         13: begin
               sx = longint'(a & mm); sy = longint'(b & mm);
               if (bit_at(a, mw-1)) sx = sx - longint'(64'd1 << mw);
               if (bit_at(b, mw-1)) sy = sy - longint'(64'd1 << mw);
               r = longint'(sx * sy) & m;
            end
         default: begin we = 0; r = 0; f = 4'h0; return; end
      endcase
      f = {v, bit_at(r, w-1), c, (r == 0)};
   endfunction

   task automatic judge(input string tag, input longint unsigned got_r, input logic [3:0] got_f,
                        input logic got_wr, input logic got_v, input longint unsigned exp_r,
                        input logic [3:0] exp_f, input logic exp_wr);
      checks++;
      if (got_r != exp_r || got_f != exp_f || got_wr != exp_wr || got_v !== 1'b1) begin
         errors++;
         $display("FAIL %s: result=%h flags=%b wr=%b valid=%b, expected result=%h flags=%b wr=%b valid=1",
                  tag, got_r, got_f, got_wr, got_v, exp_r, exp_f, exp_wr);
      end
   endtask

   // drives at a falling edge, the rising edge registers, checks at the next falling edge
   task automatic go32(input int op, input logic [31:0] a, input logic [31:0] b, input string tag);
      longint unsigned er; logic [3:0] ef; logic ew;
      model(op, a, b, 32, 16, er, ef, ew);
      v32 = 1; op32 = op[3:0]; a32 = a; b32 = b;
      @(negedge clk);
      judge(tag, r32, f32, wr32, ov32, er, ef, ew);
   endtask

   task automatic go8(input int op, input logic [7:0] a, input logic [7:0] b);
      longint unsigned er; logic [3:0] ef; logic ew;
      model(op, a, b, 8, 4, er, ef, ew);
      v8 = 1; op8 = op[3:0]; a8 = a; b8 = b;
      @(negedge clk);
      judge(tag_of(op), r8, f8, wr8, ov8, er, ef, ew);
   endtask

   initial begin
      repeat (20000 * 10) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] hold_r;
      logic [3:0]  hold_f;
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (ov32 !== 0 || wr32 !== 0 || r32 !== 0 || f32 !== 0 || ov8 !== 0 || r8 !== 0) begin
         errors++;
         $display("FAIL R1: reset outputs valid=%b wr=%b result=%h flags=%b, expected all zero",
                  ov32, wr32, r32, f32);
      end
      rst_n = 1;
      @(negedge clk);

      // 32-bit boundary values
      go32(0, 32'h7FFF_FFFF, 32'd1, "R4 overflow");
      go32(0, 32'hFFFF_FFFF, 32'd1, "R4 carry");
      go32(1, 32'h8000_0000, 32'd1, "R5 overflow");
      go32(1, 32'd0, 32'd1, "R5 borrow");
      go32(2, 32'd7, 32'd7, "R5 compare equal no write");
      go32(3, 32'hF0F0_0000, 32'h0F0F_FFFF, "R6 test no write");
      go32(11, 32'h1234_5678, 32'hDEAD_BEEF, "R6 load immediate");
      go32(8, 32'h8000_0000, 32'd1, "R8 sign change overflow");
      go32(7, 32'h4000_0000, 32'd1, "R7 overflow into sign");
      go32(7, 32'h8000_0000, 32'd1, "R7 overflow out of sign");
      go32(7, 32'h35, 32'd8, "R7 shift by 8");
      go32(7, 32'h1234_5678, 32'd0, "R10 left by zero");
      go32(8, 32'hFFFF_FFFF, 32'd0, "R10 right by zero");
      go32(9, 32'hFFFF_FFFF, 32'd0, "R10 arith by zero");
      go32(8, 32'hFFFF_FFFF, 32'd32, "R8 by width");
      go32(8, 32'hFFFF_FFFF, 32'd1, "R8 by one");
      go32(8, 32'h7FFF_FFFF, 32'd31, "R8 by 31 carry");
      go32(8, 32'h0, 32'd1, "R8 zero carry");
      go32(8, 32'hFFFF_FFFF, 32'd33, "R8 beyond width");
      go32(7, 32'hFFFF_FFFF, 32'd32, "R7 by width");
      go32(7, 32'hFFFF_FFFF, 32'hFFFF_FF00, "R7 huge amount");
      go32(9, 32'hFFFF_FFFF, 32'd32, "R9 by width");
      go32(9, 32'hFFFF_FFFF, 32'd1, "R9 by one");
      go32(9, 32'h8000_0001, 32'd33, "R9 beyond width");
      go32(9, 32'h7FFF_FFFF, 32'd30, "R9 positive");
      go32(10, 32'd1, 32'd31, "R11 rotate 31");
      go32(10, 32'h8000_0001, 32'd33, "R11 rotate modulo");
      go32(12, 32'h0000_FFFF, 32'h0000_FFFF, "R12 unsigned max");
      go32(12, 32'd23171, 32'd23171, "R12 unsigned square");
      go32(13, 32'h0000_8001, 32'h0000_7FFF, "R12 signed mixed");
      go32(13, 32'h0000_8001, 32'h0000_8001, "R12 signed square");
      go32(13, 32'h0000_8000, 32'h0000_8000, "R12 signed min square");
      go32(13, 32'hABCD_8001, 32'h1234_7FFF, "R12 upper bits ignored");
      go32(12, 32'hFFFF_0003, 32'h5555_0005, "R12 unsigned upper ignored");
      go32(14, 32'h1, 32'h2, "R13 unused code");
      go32(15, 32'h0, 32'h0, "R13 unused code");
      go32(4, 32'hFFFF_0000, 32'h0F0F_0F0F, "R6 and");
      go32(6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 xor zero");

      // R1 idle cycle holds result and flags, drops valid and write
      hold_r = r32; hold_f = f32;
      v32 = 0; op32 = 4'd0; a32 = 32'h1; b32 = 32'h1;
      @(negedge clk);
      checks++;
      if (ov32 !== 0 || wr32 !== 0 || r32 !== hold_r || f32 !== hold_f) begin
         errors++;
         $display("FAIL R1: idle valid=%b wr=%b result=%h flags=%b, expected 0 0 %h %b",
                  ov32, wr32, r32, f32, hold_r, hold_f);
      end

      // 8-bit sweep: every A, sixteen B patterns, every code (R2 R3 via flag and write checks)
      for (int op = 0; op < 16; op++) begin
         for (int a = 0; a < 256; a++) begin
            for (int j = 0; j < 16; j++) begin
               logic [7:0] bb;
               bb = (op >= 7 && op <= 10) ? 8'(j) : 8'((j * 37 + 11) & 255);
               go8(op, 8'(a), bb);
            end
         end
      end
      v8 = 0;
      @(negedge clk);
      checks++;
      if (ov8 !== 0 || wr8 !== 0) begin
         errors++;
         $display("FAIL R1: small idle valid=%b wr=%b, expected 0 0", ov8, wr8);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule